// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the hardwired control unit for a 32-bit processor that spends several clock cycles on each instruction. A Moore state machine steps the datapath through instruction fetch, register read and decode, and then an instruction-specific tail of execute, memory and writeback steps. Each state drives a fixed set of datapath strobes: write enables, multiplexer selects and a 2-bit ALU operation class. The only input besides clock and a synchronous reset is the 6-bit opcode field of the instruction register.

Six instruction kinds are sequenced: register-register operations, OR with an immediate, word load, word store, branch on equal and unconditional jump. Next-state logic is written directly as logic. There is no control store. The opcode is consulted in exactly two places: the decode step, which branches to one of five paths, and the address step, which separates loads from stores.

Top module: `multiCycleCtrl`

## Requirements
- R1: A synchronous reset puts the machine in the fetch step at the next rising edge. This holds in every state, including mid-instruction.
- R2: Fetch drives pcWrite=1, irWrite=1, aluOp=00 (add), aluSrcA=0, aluSrcB=00, pcSrc=00, and every other strobe 0. The next step is always decode.
- R3: Decode drives tgtWrite=1, extSign=1, aluOp=00, aluSrcB=10, and every other strobe 0. The next step depends on the opcode: 100011 (load) or 101011 (store) goes to the address step, 000000 (register op) to register execute, 000100 (branch) to branch complete, 001011 (OR immediate) to OR execute, and 000010 (jump) to jump.
- R4: The load path is address step, then load memory, then load writeback, then fetch. The address step drives extSign=1, aluSrcA=1, aluSrcB=11, aluOp=00. Load memory adds addrSel=1. Load writeback adds regWrite=1 and memToReg=1, with regDst=0.
- R5: Store goes from the address step to store memory, which drives memWrite=1 on top of the address-step values, and then to fetch.
- R6: Register execute drives aluSrcA=1, aluSrcB=01, aluOp=10 (function field), regDst=1. Register finish adds regWrite=1 with memToReg=0 and then returns to fetch.
- R7: Branch complete drives pcWriteCond=1, pcSrc=01 (branch target), aluOp=01 (subtract), aluSrcA=1, aluSrcB=01, and then returns to fetch.
- R8: Jump drives pcWrite=1 with pcSrc=10 (jump address) and aluOp=00, and then returns to fetch.
- R9: OR execute drives aluOp=11 (or), aluSrcA=1, aluSrcB=11, extSign=0. OR finish adds regWrite=1 with regDst=0 and then returns to fetch.
- R10: In decode, any opcode other than the six listed sends the machine back to fetch.
- R11: Outside decode and the address step, the opcode value has no effect on the state sequence or on any strobe.
- R12: memWrite and regWrite are never 1 together, and pcWriteCond=1 only with pcSrc=01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| pcWrite | output | 1 | Unconditional program counter write |
| pcWriteCond | output | 1 | Program counter write when the ALU reports zero |
| irWrite | output | 1 | Instruction register load |
| memWrite | output | 1 | Memory write strobe |
| addrSel | output | 1 | Memory read address: 0 program counter, 1 ALU result |
| regWrite | output | 1 | Register file write |
| regDst | output | 1 | Destination register: 0 rt field, 1 rd field |
| memToReg | output | 1 | Writeback source: 0 ALU, 1 memory |
| extSign | output | 1 | Immediate extension: 1 sign, 0 zero |
| tgtWrite | output | 1 | Branch target register load |
| aluSrcA | output | 1 | ALU A operand: 0 program counter, 1 register A |
| aluSrcB | output | 2 | ALU B operand: 00 four, 01 register B, 10 shifted immediate, 11 immediate |
| pcSrc | output | 2 | Program counter source: 00 ALU, 01 branch target, 10 jump address |
| aluOp | output | 2 | ALU class: 00 add, 01 subtract, 10 function field, 11 or |

## Verification
Two events can land on the same clock edge: the opcode-driven dispatch out of decode or the address step, and a synchronous reset. The bench raises reset while the machine sits in decode with a load opcode, and again in the load writeback step. It then requires the fetch strobes on the next cycle and not the decode target. During every instruction the bench drives the true opcode only in the decode and address steps and a changing scramble value in all other steps. A design that reads the opcode outside those steps therefore breaks the expected strobe vector, which the bench computes from the requirement table.

// File: rtl/mcCtrlPkg.sv
package mcCtrlPkg;

  localparam int OPC_W   = 6;
  localparam int STATE_W = 4;
  localparam int SEL_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDMEM  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STMEM  = 4'd5,
    ST_REXE   = 4'd6,
    ST_RFIN   = 4'd7,
    ST_BRCH   = 4'd8,
    ST_JUMP   = 4'd9,
    ST_OREXE  = 4'd10,
    ST_ORFIN  = 4'd11
  } seqState_t;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001011;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  typedef enum logic [2:0] {
    OPK_MEM  = 3'd0,
    OPK_REG  = 3'd1,
    OPK_BR   = 3'd2,
    OPK_JMP  = 3'd3,
    OPK_ORI  = 3'd4,
    OPK_BAD  = 3'd5
  } opKind_t;

  typedef enum logic [SEL_W-1:0] {
    ALU_ADD   = 2'b00,
    ALU_SUB   = 2'b01,
    ALU_FUNCT = 2'b10,
    ALU_OR    = 2'b11
  } aluOp_t;

  typedef enum logic [SEL_W-1:0] {
    PCS_SEQ    = 2'b00,
    PCS_BRANCH = 2'b01,
    PCS_JUMP   = 2'b10
  } pcSrc_t;

  typedef enum logic [SEL_W-1:0] {
    SRCB_FOUR  = 2'b00,
    SRCB_REGB  = 2'b01,
    SRCB_SHIMM = 2'b10,
    SRCB_IMM   = 2'b11
  } srcB_t;

  typedef struct packed {
    logic   pcWrite;
    logic   pcWriteCond;
    logic   irWrite;
    logic   memWrite;
    logic   addrSel;
    logic   regWrite;
    logic   regDst;
    logic   memToReg;
    logic   extSign;
    logic   tgtWrite;
    logic   aluSrcA;
    srcB_t  aluSrcB;
    pcSrc_t pcSrc;
    aluOp_t aluOp;
  } ctrlStrobes_t;

  localparam ctrlStrobes_t STROBES_IDLE = '{
    pcWrite: 1'b0, pcWriteCond: 1'b0, irWrite: 1'b0, memWrite: 1'b0,
    addrSel: 1'b0, regWrite: 1'b0, regDst: 1'b0, memToReg: 1'b0,
    extSign: 1'b0, tgtWrite: 1'b0, aluSrcA: 1'b0, aluSrcB: SRCB_FOUR,
    pcSrc: PCS_SEQ, aluOp: ALU_ADD
  };

endpackage

// File: rtl/mcOpDecode.sv
module mcOpDecode
  import mcCtrlPkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output opKind_t          opKind,
  output logic             isLoad
);

  always_comb begin
    isLoad = 1'b0;
    case (opcode)
      OPC_LOAD:  begin opKind = OPK_MEM; isLoad = 1'b1; end
      OPC_STORE: opKind = OPK_MEM;
      OPC_RTYPE: opKind = OPK_REG;
      OPC_BEQ:   opKind = OPK_BR;
      OPC_JUMP:  opKind = OPK_JMP;
      OPC_ORI:   opKind = OPK_ORI;
      default:   opKind = OPK_BAD;
    endcase
  end

endmodule

// File: rtl/mcStateSeq.sv
module mcStateSeq
  import mcCtrlPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  opKind_t   opKind,
  input  logic      isLoad,
  output seqState_t curState
);

  seqState_t nextState;

  // Dispatch from decode: one target per instruction kind
  function automatic seqState_t decodeTarget(input opKind_t kind);
    case (kind)
      OPK_MEM: return ST_ADDR;
      OPK_REG: return ST_REXE;
      OPK_BR:  return ST_BRCH;
      OPK_JMP: return ST_JUMP;
      OPK_ORI: return ST_OREXE;
      default: return ST_FETCH;
    endcase
  endfunction

  always_comb begin
    case (curState)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: nextState = decodeTarget(opKind);
      ST_ADDR:   nextState = isLoad ? ST_LDMEM : ST_STMEM;
      ST_LDMEM:  nextState = ST_LDWB;
      ST_REXE:   nextState = ST_RFIN;
      ST_OREXE:  nextState = ST_ORFIN;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_FETCH;
    else     curState <= nextState;
  end

endmodule

// File: rtl/mcStrobeGen.sv
module mcStrobeGen
  import mcCtrlPkg::*;
(
  input  seqState_t    curState,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = STROBES_IDLE;
    case (curState)
      ST_FETCH: begin
        strobes.pcWrite = 1'b1;
        strobes.irWrite = 1'b1;
      end
      ST_DECODE: begin
        strobes.tgtWrite = 1'b1;
        strobes.extSign  = 1'b1;
        strobes.aluSrcB  = SRCB_SHIMM;
      end
      ST_ADDR, ST_LDMEM, ST_LDWB, ST_STMEM: begin
        strobes.extSign  = 1'b1;
        strobes.aluSrcA  = 1'b1;
        strobes.aluSrcB  = SRCB_IMM;
        strobes.addrSel  = (curState == ST_LDMEM);
        strobes.regWrite = (curState == ST_LDWB);
        strobes.memToReg = (curState == ST_LDWB);
        strobes.memWrite = (curState == ST_STMEM);
      end
      ST_REXE, ST_RFIN: begin
        strobes.aluSrcA  = 1'b1;
        strobes.aluSrcB  = SRCB_REGB;
        strobes.aluOp    = ALU_FUNCT;
        strobes.regDst   = 1'b1;
        strobes.regWrite = (curState == ST_RFIN);
      end
      ST_BRCH: begin
        strobes.pcWriteCond = 1'b1;
        strobes.pcSrc       = PCS_BRANCH;
        strobes.aluOp       = ALU_SUB;
        strobes.aluSrcA     = 1'b1;
        strobes.aluSrcB     = SRCB_REGB;
      end
      ST_JUMP: begin
        strobes.pcWrite = 1'b1;
        strobes.pcSrc   = PCS_JUMP;
      end
      ST_OREXE, ST_ORFIN: begin
        strobes.aluOp    = ALU_OR;
        strobes.aluSrcA  = 1'b1;
        strobes.aluSrcB  = SRCB_IMM;
        strobes.regWrite = (curState == ST_ORFIN);
      end
      default: strobes = STROBES_IDLE;
    endcase
  end

endmodule

// File: rtl/multiCycleCtrl.sv
module multiCycleCtrl
  import mcCtrlPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             pcWrite,
  output logic             pcWriteCond,
  output logic             irWrite,
  output logic             memWrite,
  output logic             addrSel,
  output logic             regWrite,
  output logic             regDst,
  output logic             memToReg,
  output logic             extSign,
  output logic             tgtWrite,
  output logic             aluSrcA,
  output logic [SEL_W-1:0] aluSrcB,
  output logic [SEL_W-1:0] pcSrc,
  output logic [SEL_W-1:0] aluOp
);

  opKind_t      opKind;
  logic         isLoad;
  seqState_t    curState;
  ctrlStrobes_t strobes;

  mcOpDecode  opDec  (.opcode(opcode), .opKind(opKind), .isLoad(isLoad));
  mcStateSeq  seq    (.clk(clk), .rst(rst), .opKind(opKind), .isLoad(isLoad),
                      .curState(curState));
  mcStrobeGen strGen (.curState(curState), .strobes(strobes));

  assign pcWrite     = strobes.pcWrite;
  assign pcWriteCond = strobes.pcWriteCond;
  assign irWrite     = strobes.irWrite;
  assign memWrite    = strobes.memWrite;
  assign addrSel     = strobes.addrSel;
  assign regWrite    = strobes.regWrite;
  assign regDst      = strobes.regDst;
  assign memToReg    = strobes.memToReg;
  assign extSign     = strobes.extSign;
  assign tgtWrite    = strobes.tgtWrite;
  assign aluSrcA     = strobes.aluSrcA;
  assign aluSrcB     = strobes.aluSrcB;
  assign pcSrc       = strobes.pcSrc;
  assign aluOp       = strobes.aluOp;

endmodule

// File: rtl/multiCycleCtrlChk.sv
module multiCycleCtrlChk
  import mcCtrlPkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opcode,
  input logic             pcWrite,
  input logic             pcWriteCond,
  input logic             irWrite,
  input logic             memWrite,
  input logic             regWrite,
  input logic             extSign,
  input logic             tgtWrite,
  input logic [SEL_W-1:0] pcSrc
);

  logic knownOp;
  assign knownOp = (opcode == OPC_RTYPE) || (opcode == OPC_BEQ) ||
                   (opcode == OPC_LOAD)  || (opcode == OPC_STORE) ||
                   (opcode == OPC_ORI)   || (opcode == OPC_JUMP);

  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irWrite && pcWrite && !tgtWrite));

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
    irWrite |=> (tgtWrite && extSign && !irWrite));

  assert_branch_dispatch_R7: assert property (@(posedge clk) disable iff (rst)
    (tgtWrite && opcode == OPC_BEQ) |=> pcWriteCond);

  assert_branch_returns_R7: assert property (@(posedge clk) disable iff (rst)
    pcWriteCond |=> irWrite);

  assert_jump_dispatch_R8: assert property (@(posedge clk) disable iff (rst)
    (tgtWrite && opcode == OPC_JUMP) |=> (pcWrite && pcSrc == 2'b10));

  assert_bad_opcode_R10: assert property (@(posedge clk) disable iff (rst)
    (tgtWrite && !knownOp) |=> irWrite);

  assert_no_mem_reg_clash_R12: assert property (@(posedge clk) disable iff (rst)
    !(memWrite && regWrite));

  assert_cond_uses_target_R12: assert property (@(posedge clk) disable iff (rst)
    pcWriteCond |-> (pcSrc == 2'b01));

  assert_single_phase_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irWrite, tgtWrite, memWrite, pcWriteCond}));

endmodule

bind multiCycleCtrl multiCycleCtrlChk chk (
  .clk(clk), .rst(rst), .opcode(opcode), .pcWrite(pcWrite),
  .pcWriteCond(pcWriteCond), .irWrite(irWrite), .memWrite(memWrite),
  .regWrite(regWrite), .extSign(extSign), .tgtWrite(tgtWrite), .pcSrc(pcSrc)
);

// File: tb/multiCycleCtrl_test.sv
module multiCycleCtrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic pcWrite, pcWriteCond, irWrite, memWrite, addrSel, regWrite;
  logic regDst, memToReg, extSign, tgtWrite, aluSrcA;
  logic [1:0] aluSrcB, pcSrc, aluOp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  multiCycleCtrl uut (
    .clk(clk), .rst(rst), .opcode(opcode), .pcWrite(pcWrite),
    .pcWriteCond(pcWriteCond), .irWrite(irWrite), .memWrite(memWrite),
    .addrSel(addrSel), .regWrite(regWrite), .regDst(regDst),
    .memToReg(memToReg), .extSign(extSign), .tgtWrite(tgtWrite),
    .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .pcSrc(pcSrc), .aluOp(aluOp)
  );

  // {pcW,pcWC,irW,memW,addrSel,regW,regDst,m2r,ext,tgtW,srcA,srcB,pcSrc,aluOp}
  function automatic logic [16:0] pack(input logic pw, pwc, irw, mw, ad, rw, rd,
                                       m2r, ex, tw, sa, input logic [1:0] sb,
                                       ps, op);
    return {pw, pwc, irw, mw, ad, rw, rd, m2r, ex, tw, sa, sb, ps, op};
  endfunction

  // Expected strobe vector per step, from the requirement table
  function automatic logic [16:0] expVec(input int s);
    case (s)
      0:  return pack(1,0,1,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b00); // R2
      1:  return pack(0,0,0,0,0,0,0,0,1,1,0,2'b10,2'b00,2'b00); // R3
      2:  return pack(0,0,0,0,0,0,0,0,1,0,1,2'b11,2'b00,2'b00); // R4
      3:  return pack(0,0,0,0,1,0,0,0,1,0,1,2'b11,2'b00,2'b00); // R4
      4:  return pack(0,0,0,0,0,1,0,1,1,0,1,2'b11,2'b00,2'b00); // R4
      5:  return pack(0,0,0,1,0,0,0,0,1,0,1,2'b11,2'b00,2'b00); // R5
      6:  return pack(0,0,0,0,0,0,1,0,0,0,1,2'b01,2'b00,2'b10); // R6
      7:  return pack(0,0,0,0,0,1,1,0,0,0,1,2'b01,2'b00,2'b10); // R6
      8:  return pack(0,1,0,0,0,0,0,0,0,0,1,2'b01,2'b01,2'b01); // R7
      9:  return pack(1,0,0,0,0,0,0,0,0,0,0,2'b00,2'b10,2'b00); // R8
      10: return pack(0,0,0,0,0,0,0,0,0,0,1,2'b11,2'b00,2'b11); // R9
      default: return pack(0,0,0,0,0,1,0,0,0,0,1,2'b11,2'b00,2'b11); // R9
    endcase
  endfunction

  function automatic string reqOf(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R4";
      5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      9: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int nextOf(input int s, input logic [5:0] op);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'b100011 || op == 6'b101011) return 2;
        if (op == 6'b000000) return 6;
        if (op == 6'b000100) return 8;
        if (op == 6'b000010) return 9;
        if (op == 6'b001011) return 10;
        return 0;
      end
      2: return (op == 6'b100011) ? 3 : 5;
      3: return 4;
      6: return 7;
      10: return 11;
      default: return 0;
    endcase
  endfunction

  function automatic logic [16:0] gotVec();
    return {pcWrite, pcWriteCond, irWrite, memWrite, addrSel, regWrite, regDst,
            memToReg, extSign, tgtWrite, aluSrcA, aluSrcB, pcSrc, aluOp};
  endfunction

  task automatic checkState(input int s, input string tag);
    checks++;
    if (gotVec() !== expVec(s)) begin
      errors++;
      $display("FAIL %s step %0d: got %b expected %b", tag, s, gotVec(), expVec(s));
    end
    checks++;
    if ((memWrite && regWrite) || (pcWriteCond && pcSrc != 2'b01)) begin
      errors++;
      $display("FAIL R12 step %0d: got mw=%b rw=%b pwc=%b ps=%b expected exclusive",
               s, memWrite, regWrite, pcWriteCond, pcSrc);
    end
  endtask

  initial begin
    int expState;
    int prevState;
    int nxt;
    int cyc;
    string tag;
    logic [5:0] scramble;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkState(0, "R1");
    rst = 1'b0;
    expState = 0;
    cyc = 0;
    // Exhaustive opcode sweep; true opcode only in decode and address steps
    for (int op = 0; op < 64; op++) begin
      prevState = -1;
      for (int step = 0; step < 8; step++) begin
        cyc++;
        scramble = 6'((op * 13 + cyc * 29 + 5) & 63);
        if (expState == 1 || expState == 2) opcode = 6'(op);
        else                                opcode = scramble;
        if (prevState == 1 && expState == 0) tag = "R10";
        else if (expState == 1 || expState == 2) tag = reqOf(expState);
        else tag = {reqOf(expState), " R11"};
        if (step > 0 || op == 0) checkState(expState, tag);
        nxt = nextOf(expState, opcode);
        @(posedge clk);
        prevState = expState;
        expState = nxt;
        @(negedge clk);
        if (expState == 0) break;
      end
      checkState(0, (prevState == 1) ? "R10" : "R2");
    end
    // Reset in the same cycle as the decode dispatch
    opcode = 6'b100011;
    @(posedge clk); @(negedge clk);
    checkState(1, "R3");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    checkState(0, "R1");
    rst = 1'b0;
    // Reset during load writeback
    @(posedge clk); @(negedge clk);
    checkState(1, "R3");
    @(posedge clk); @(negedge clk);
    checkState(2, "R4");
    @(posedge clk); @(negedge clk);
    checkState(3, "R4");
    @(posedge clk); @(negedge clk);
    checkState(4, "R4");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    checkState(0, "R1");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    checkState(1, "R1");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule